// File: doc/BRIEF.md
# Asynchronous Memory Strobe Sequencer

This block drives the control strobes of one chip-select on an external parallel memory: chip select, address valid, output enable and write enable, all active low. Each strobe has its own assert tick and deassert tick, counted in functional-clock cycles from the start of a memory cycle. The deassert ticks of chip select and address valid are held separately for reads and writes. Read cycles and write cycles also have separate total lengths. Besides the four strobes, the block produces two active-high outputs. One is a one-cycle read-data capture pulse. The other is a write-data drive window that opens at a programmable tick.

A host fills the timing fields through a simple register write port and can read them back. A cycle starts through a valid/ready request port that carries the direction. The request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low from the edge after acceptance until the clock after `done`, so a requester that holds `req_valid` simply waits; any request presented while the block is busy has no effect. The block also holds a divider setting of 1 to 4 and a sync-enable bit. From these it produces a one-cycle enable pulse that marks the edges of a synchronous-mode memory clock. The page-burst and write-access tick fields are storage only: they can be written and read back but drive no output.

Top module: `memstrobe_timer`

## Requirements
- R1: After reset `cs_n`, `adv_n`, `oe_n`, `we_n` are 1; `done`, `data_capture`, `data_drive` and `sync_clk_en` are 0; `req_ready` is 1.
- R2: Register map. Each field sits at bit 8*k of its word, low-aligned, and unused bits read 0.
  - Address 0: chip-select assert (4b), read deassert (5b), write deassert (5b).
  - Address 1: the same three fields for address valid.
  - Address 2: OE assert (4b), OE deassert (5b), WE assert (4b), WE deassert (5b).
  - Address 3: read length, write length, capture tick and write-access tick, each 5b.
  - Address 4: drive tick (4b), page-burst tick (4b), divider minus one (2b), sync enable (1b).
  - Addresses 5 to 7 read 0, and writes to them are ignored.
- R3: A request is accepted on an edge with `req_valid` and `req_ready` high. `req_ready` is 0 from the next clock until the clock after `done`, then 1 again.
- R4: Tick t is the clock period that follows the t-th edge after the acceptance edge (the acceptance edge's successor period is tick 0). `done` is 1 exactly in tick L, where L is the read length or the write length according to the direction taken at acceptance.
- R5: `cs_n` is 0 in tick t exactly when assert <= t < deassert (the deassert for the cycle's direction) and t < L.
- R6: `adv_n` follows the same rule as R5 using the address-valid fields.
- R7: `oe_n` follows that rule on read cycles only, and `we_n` follows it on write cycles only; each stays 1 in the other direction.
- R8: A strobe whose assert tick is equal to or later than its deassert tick is never asserted during the cycle.
- R9: On read cycles `data_capture` is 1 in exactly the tick equal to the capture field, provided that tick is below L; it is never 1 on write cycles.
- R10: On write cycles `data_drive` is 1 for the ticks t with drive tick <= t < L; it is never 1 on read cycles.
- R11: With sync enable set, `sync_clk_en` pulses for one clock every (divider field + 1) clocks; with sync enable clear it stays 0.
- R12: Any change of `req_valid` or `req_write` while `req_ready` is 0 leaves the running cycle unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | functional clock |
| rst_n | input | 1 | asynchronous active-low reset |
| cfg_we | input | 1 | register write strobe |
| cfg_addr | input | 3 | register word address |
| cfg_wdata | input | 32 | register write data |
| cfg_rdata | output | 32 | register read data for `cfg_addr` (combinational) |
| req_valid | input | 1 | memory cycle request |
| req_ready | output | 1 | block can take a request |
| req_write | input | 1 | direction of the request, 1 = write |
| done | output | 1 | one-cycle end-of-cycle pulse |
| cs_n | output | 1 | chip select, active low |
| adv_n | output | 1 | address valid, active low |
| oe_n | output | 1 | output enable, active low |
| we_n | output | 1 | write enable, active low |
| data_capture | output | 1 | read-data capture pulse |
| data_drive | output | 1 | write-data drive window |
| sync_clk_en | output | 1 | synchronous memory clock enable pulse |

## Verification
Every cycle output is due in the clock period that follows the t-th edge after the acceptance edge. The bench takes the acceptance edge as its reference and samples every output at each falling edge after it. It predicts each strobe, capture, drive and done value for that tick arithmetically from the programmed fields, and expects `req_ready` back exactly one period after the tick where done appears. The divider is checked by measuring the falling-edge distance between consecutive enable pulses once the counter has settled, and register read-back is sampled a moment after the address changes.

// File: rtl/memstrobe_pkg.sv
package memstrobe_pkg;
  localparam int ON_W   = 4;
  localparam int OFF_W  = 5;
  localparam int TICK_W = 5;
  localparam int DIV_W  = 2;
  localparam int NWIN   = 6;

  typedef struct packed {
    logic [ON_W-1:0]   cs_on;
    logic [OFF_W-1:0]  cs_rd_off;
    logic [OFF_W-1:0]  cs_wr_off;
    logic [ON_W-1:0]   av_on;
    logic [OFF_W-1:0]  av_rd_off;
    logic [OFF_W-1:0]  av_wr_off;
    logic [ON_W-1:0]   oe_on;
    logic [OFF_W-1:0]  oe_off;
    logic [ON_W-1:0]   we_on;
    logic [OFF_W-1:0]  we_off;
    logic [TICK_W-1:0] rd_len;
    logic [TICK_W-1:0] wr_len;
    logic [TICK_W-1:0] cap_tick;
    logic [TICK_W-1:0] wr_access;
    logic [ON_W-1:0]   drv_tick;
    logic [ON_W-1:0]   burst_tick;
    logic [DIV_W-1:0]  div_m1;
    logic              sync_en;
  } ms_cfg_t;
endpackage

// File: rtl/memstrobe_regs.sv
module memstrobe_regs
  import memstrobe_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output ms_cfg_t           cfg
);
  ms_cfg_t cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (we) begin
      case (addr)
        ADDR_W'(0): begin
          cfg_q.cs_on     <= wdata[ON_W-1:0];
          cfg_q.cs_rd_off <= wdata[8 +: OFF_W];
          cfg_q.cs_wr_off <= wdata[16 +: OFF_W];
        end
        ADDR_W'(1): begin
          cfg_q.av_on     <= wdata[ON_W-1:0];
          cfg_q.av_rd_off <= wdata[8 +: OFF_W];
          cfg_q.av_wr_off <= wdata[16 +: OFF_W];
        end
        ADDR_W'(2): begin
          cfg_q.oe_on  <= wdata[ON_W-1:0];
          cfg_q.oe_off <= wdata[8 +: OFF_W];
          cfg_q.we_on  <= wdata[16 +: ON_W];
          cfg_q.we_off <= wdata[24 +: OFF_W];
        end
        ADDR_W'(3): begin
          cfg_q.rd_len    <= wdata[TICK_W-1:0];
          cfg_q.wr_len    <= wdata[8 +: TICK_W];
          cfg_q.cap_tick  <= wdata[16 +: TICK_W];
          cfg_q.wr_access <= wdata[24 +: TICK_W];
        end
        ADDR_W'(4): begin
          cfg_q.drv_tick   <= wdata[ON_W-1:0];
          cfg_q.burst_tick <= wdata[8 +: ON_W];
          cfg_q.div_m1     <= wdata[16 +: DIV_W];
          cfg_q.sync_en    <= wdata[24];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_W'(0): begin
        rdata[ON_W-1:0]    = cfg_q.cs_on;
        rdata[8 +: OFF_W]  = cfg_q.cs_rd_off;
        rdata[16 +: OFF_W] = cfg_q.cs_wr_off;
      end
      ADDR_W'(1): begin
        rdata[ON_W-1:0]    = cfg_q.av_on;
        rdata[8 +: OFF_W]  = cfg_q.av_rd_off;
        rdata[16 +: OFF_W] = cfg_q.av_wr_off;
      end
      ADDR_W'(2): begin
        rdata[ON_W-1:0]    = cfg_q.oe_on;
        rdata[8 +: OFF_W]  = cfg_q.oe_off;
        rdata[16 +: ON_W]  = cfg_q.we_on;
        rdata[24 +: OFF_W] = cfg_q.we_off;
      end
      ADDR_W'(3): begin
        rdata[TICK_W-1:0]   = cfg_q.rd_len;
        rdata[8 +: TICK_W]  = cfg_q.wr_len;
        rdata[16 +: TICK_W] = cfg_q.cap_tick;
        rdata[24 +: TICK_W] = cfg_q.wr_access;
      end
      ADDR_W'(4): begin
        rdata[ON_W-1:0]    = cfg_q.drv_tick;
        rdata[8 +: ON_W]   = cfg_q.burst_tick;
        rdata[16 +: DIV_W] = cfg_q.div_m1;
        rdata[24]          = cfg_q.sync_en;
      end
      default: rdata = '0;
    endcase
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/memstrobe_seq.sv
module memstrobe_seq #(
  parameter int TICK_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [TICK_W-1:0] rd_len,
  input  logic [TICK_W-1:0] wr_len,
  output logic              req_ready,
  output logic              done,
  output logic              busy_nx,
  output logic              write_nx,
  output logic [TICK_W-1:0] tick_nx,
  output logic [TICK_W-1:0] len_nx
);
  logic              busy_q, write_q;
  logic [TICK_W-1:0] tick_q;
  logic [TICK_W-1:0] cur_len;

  assign cur_len = write_q ? wr_len : rd_len;

  always_comb begin
    busy_nx  = busy_q;
    write_nx = write_q;
    tick_nx  = tick_q;
    if (busy_q) begin
      if (tick_q == cur_len) busy_nx = 1'b0;
      else                   tick_nx = tick_q + 1'b1;
    end else if (req_valid) begin
      busy_nx  = 1'b1;
      write_nx = req_write;
      tick_nx  = '0;
    end
  end

  assign len_nx = write_nx ? wr_len : rd_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      write_q <= 1'b0;
      tick_q  <= '0;
    end else begin
      busy_q  <= busy_nx;
      write_q <= write_nx;
      tick_q  <= tick_nx;
    end
  end

  assign req_ready = !busy_q;
  assign done      = busy_q && (tick_q == cur_len);
endmodule

// File: rtl/memstrobe_window.sv
module memstrobe_window #(
  parameter int TICK_W     = 5,
  parameter bit ACTIVE_LOW = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy_nx,
  input  logic              qual,
  input  logic [TICK_W-1:0] tick_nx,
  input  logic [TICK_W-1:0] len_nx,
  input  logic [TICK_W:0]   on_tick,
  input  logic [TICK_W:0]   off_tick,
  output logic              q
);
  logic [TICK_W:0] t_ext;
  logic            active;

  assign t_ext  = {1'b0, tick_nx};
  assign active = busy_nx && qual && (t_ext >= on_tick) &&
                  (t_ext < off_tick) && (tick_nx < len_nx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= ACTIVE_LOW;
    else        q <= ACTIVE_LOW ? !active : active;
  end
endmodule

// File: rtl/memstrobe_clkdiv.sv
module memstrobe_clkdiv #(
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [DIV_W-1:0] div_m1,
  output logic             pulse
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pulse <= 1'b0;
    end else if (!enable) begin
      cnt_q <= '0;
      pulse <= 1'b0;
    end else if (cnt_q == div_m1) begin
      cnt_q <= '0;
      pulse <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      pulse <= 1'b0;
    end
  end
endmodule

// File: rtl/memstrobe_timer.sv
module memstrobe_timer
  import memstrobe_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  output logic              done,
  output logic              cs_n,
  output logic              adv_n,
  output logic              oe_n,
  output logic              we_n,
  output logic              data_capture,
  output logic              data_drive
  ,output logic             sync_clk_en
);
  localparam int WIN_W = TICK_W + 1;

  ms_cfg_t           cfg;
  logic              busy_nx, write_nx;
  logic [TICK_W-1:0] tick_nx, len_nx;
  logic [WIN_W-1:0]  on_a  [NWIN];
  logic [WIN_W-1:0]  off_a [NWIN];
  logic              qual_a[NWIN];
  logic              q_a   [NWIN];

  memstrobe_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .cfg(cfg)
  );

  memstrobe_seq #(.TICK_W(TICK_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .rd_len(cfg.rd_len), .wr_len(cfg.wr_len), .req_ready(req_ready),
    .done(done), .busy_nx(busy_nx), .write_nx(write_nx),
    .tick_nx(tick_nx), .len_nx(len_nx)
  );

  // window table: 0 cs, 1 adv, 2 oe, 3 we, 4 capture, 5 drive
  always_comb begin
    on_a[0]   = WIN_W'(cfg.cs_on);
    off_a[0]  = WIN_W'(write_nx ? cfg.cs_wr_off : cfg.cs_rd_off);
    qual_a[0] = 1'b1;
    on_a[1]   = WIN_W'(cfg.av_on);
    off_a[1]  = WIN_W'(write_nx ? cfg.av_wr_off : cfg.av_rd_off);
    qual_a[1] = 1'b1;
    on_a[2]   = WIN_W'(cfg.oe_on);
    off_a[2]  = WIN_W'(cfg.oe_off);
    qual_a[2] = !write_nx;
    on_a[3]   = WIN_W'(cfg.we_on);
    off_a[3]  = WIN_W'(cfg.we_off);
    qual_a[3] = write_nx;
    on_a[4]   = WIN_W'(cfg.cap_tick);
    off_a[4]  = WIN_W'(cfg.cap_tick) + 1'b1;
    qual_a[4] = !write_nx;
    on_a[5]   = WIN_W'(cfg.drv_tick);
    off_a[5]  = WIN_W'(len_nx);
    qual_a[5] = write_nx;
  end

  for (genvar i = 0; i < NWIN; i++) begin : g_win
    memstrobe_window #(.TICK_W(TICK_W), .ACTIVE_LOW(i < 4)) u_win (
      .clk(clk), .rst_n(rst_n), .busy_nx(busy_nx), .qual(qual_a[i]),
      .tick_nx(tick_nx), .len_nx(len_nx), .on_tick(on_a[i]),
      .off_tick(off_a[i]), .q(q_a[i])
    );
  end

  assign cs_n         = q_a[0];
  assign adv_n        = q_a[1];
  assign oe_n         = q_a[2];
  assign we_n         = q_a[3];
  assign data_capture = q_a[4];
  assign data_drive   = q_a[5];

  memstrobe_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .enable(cfg.sync_en),
    .div_m1(cfg.div_m1), .pulse(sync_clk_en)
  );
endmodule

// File: rtl/memstrobe_timer_chk.sv
module memstrobe_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic done,
  input logic cs_n,
  input logic adv_n,
  input logic oe_n,
  input logic we_n,
  input logic data_capture,
  input logic data_drive
);
  AST_ACCEPT_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R3
  AST_DONE_THEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> req_ready); // R3
  AST_DONE_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_ready); // R3
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (cs_n && adv_n && oe_n && we_n && !data_capture && !data_drive)); // R5
  AST_OE_WE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!oe_n && !we_n)); // R7
  AST_CAPTURE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    data_capture |=> !data_capture); // R9
  AST_CAP_DRV_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(data_capture && data_drive)); // R10
endmodule

bind memstrobe_timer memstrobe_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .done(done), .cs_n(cs_n), .adv_n(adv_n), .oe_n(oe_n), .we_n(we_n),
  .data_capture(data_capture), .data_drive(data_drive)
);

// File: tb/sim_memstrobe_timer.sv
`timescale 1ns/1ps
module sim_memstrobe_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic        req_ready, done, cs_n, adv_n, oe_n, we_n;
  logic        data_capture, data_drive, sync_clk_en;

  int checks = 0, errors = 0;
  bit finished = 0;
  int cs_on, cs_ro, cs_wo, av_on, av_ro, av_wo;
  int oe_on, oe_off, we_on, we_off, rd_len, wr_len, cap, mux;

  always #10 clk = ~clk;

  memstrobe_timer u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .done(done), .cs_n(cs_n),
    .adv_n(adv_n), .oe_n(oe_n), .we_n(we_n), .data_capture(data_capture),
    .data_drive(data_drive), .sync_clk_en(sync_clk_en)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_chk(input int a, input logic [31:0] exp);
    @(negedge clk);
    cfg_addr = 3'(a);
    #1;
    chk("R2", $sformatf("readback addr %0d", a), cfg_rdata, exp);
  endtask

  function automatic bit win(input int on, input int off, input int t, input int len);
    return (t >= on) && (t < off) && (t < len);
  endfunction

  task automatic program_all();
    wr(0, 32'(cs_on | (cs_ro << 8) | (cs_wo << 16)));
    wr(1, 32'(av_on | (av_ro << 8) | (av_wo << 16)));
    wr(2, 32'(oe_on | (oe_off << 8) | (we_on << 16) | (we_off << 24)));
    wr(3, 32'(rd_len | (wr_len << 8) | (cap << 16)));
    wr(4, 32'(mux));
  endtask

  task automatic run(input bit w);
    int len;
    len = w ? wr_len : rd_len;
    @(negedge clk);
    chk("R3", "ready before request", req_ready, 1);
    req_valid = 1'b1; req_write = w;
    for (int t = 0; t <= 40; t++) begin
      @(negedge clk);
      req_write = !w; // R12 probe: changes while busy must be ignored
      chk("R3", "ready low while busy", req_ready, 0);
      chk("R4", $sformatf("done t=%0d", t), done, t == len);
      chk("R5", $sformatf("cs_n t=%0d", t), cs_n, !win(cs_on, w ? cs_wo : cs_ro, t, len));
      chk("R6", $sformatf("adv_n t=%0d", t), adv_n, !win(av_on, w ? av_wo : av_ro, t, len));
      chk("R7", $sformatf("oe_n t=%0d", t), oe_n, !(!w && win(oe_on, oe_off, t, len)));
      chk("R7", $sformatf("we_n t=%0d", t), we_n, !(w && win(we_on, we_off, t, len)));
      chk("R9", $sformatf("capture t=%0d", t), data_capture, !w && win(cap, cap + 1, t, len));
      chk("R10", $sformatf("drive t=%0d", t), data_drive, w && win(mux, len, t, len));
      if (t == len) begin
        req_valid = 1'b0;
        break;
      end
      if (t == 40) chk("R4", "cycle never ended", 0, 1);
    end
    @(negedge clk);
    chk("R3", "ready after done", req_ready, 1);
    chk("R12", "idle strobes", {cs_n, adv_n, oe_n, we_n}, 4'hF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "strobes", {cs_n, adv_n, oe_n, we_n}, 4'hF);
    chk("R1", "outputs", {done, data_capture, data_drive, sync_clk_en}, 4'h0);
    chk("R1", "ready", req_ready, 1);

    // R2 readback and masking
    for (int a = 0; a < 8; a++) wr(a, 32'hFFFF_FFFF);
    rd_chk(0, 32'h001F_1F0F);
    rd_chk(1, 32'h001F_1F0F);
    rd_chk(2, 32'h1F0F_1F0F);
    rd_chk(3, 32'h1F1F_1F1F);
    rd_chk(4, 32'h0103_0F0F);
    rd_chk(5, 32'h0);
    rd_chk(7, 32'h0);
    wr(4, 32'h0);

    // R11 divider
    for (int d = 0; d < 4; d++) begin
      int gap, cnt;
      wr(4, 32'h0100_0000 | 32'(d << 16));
      repeat (8) @(negedge clk);
      gap = 0;
      while (!sync_clk_en && gap < 10) begin @(negedge clk); gap++; end
      cnt = 0; gap = 0;
      for (int n = 1; n <= 24; n++) begin
        @(negedge clk);
        if (sync_clk_en) begin
          cnt++;
          if (gap == 0) gap = n;
        end
      end
      chk("R11", $sformatf("pulse spacing div=%0d", d + 1), gap, d + 1);
      chk("R11", $sformatf("pulse count div=%0d", d + 1), cnt, 24 / (d + 1));
    end
    wr(4, 32'h0003_0000);
    begin
      int cnt = 0;
      for (int n = 0; n < 20; n++) begin @(negedge clk); if (sync_clk_en) cnt++; end
      chk("R11", "no pulse when disabled", cnt, 0);
    end

    // directed: distinct read and write lengths (R4), late capture (R9)
    cs_on = 1; cs_ro = 4; cs_wo = 8; av_on = 0; av_ro = 2; av_wo = 3;
    oe_on = 2; oe_off = 5; we_on = 3; we_off = 7; rd_len = 5; wr_len = 9;
    cap = 6; mux = 2;
    program_all();
    run(0);
    run(1);
    cap = 3;
    program_all();
    run(0);

    // R8: sweep including equal and reversed assert/deassert ticks
    for (int a = 0; a < 6; a++)
      for (int b = 0; b < 7; b++)
        for (int l = 0; l < 8; l++) begin
          cs_on = a; cs_ro = b; cs_wo = b + 1;
          av_on = b; av_ro = a; av_wo = a;
          oe_on = a; oe_off = b + 1; we_on = a + 1; we_off = b;
          rd_len = l; wr_len = l; cap = b; mux = a;
          program_all();
          run(0);
          run(1);
        end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule